// File: doc/BRIEF.md
# Byte-Serial SPI Master Engine

This block is an SPI master that software drives through a small 32-bit register bus. Software writes bytes into a 64-entry transmit FIFO and sets two 24-bit counts. One count gives the length of the burst, and the other gives how many of those bytes come from the transmit FIFO. A write of the exchange bit in the control register starts the burst. The engine shifts each byte out MSB first and captures every byte it receives into a 64-entry receive FIFO. Software then drains the receive FIFO by reading the receive data register. The exchange bit reads back as 1 while the burst runs and clears itself after the last byte is received.

The serial clock is paced by a one-cycle enable pulse that comes from an external divider. Each pulse advances the serial clock by one half-period. Clock polarity and clock phase are set in the control register. Each FIFO can be emptied on its own through a reset bit. Two chip-select lines are provided. The selected line can be asserted automatically for the length of a burst, or it can follow a level bit that software sets. A control bit sets the polarity of the chip-select lines.

Top module: `spx_master_top`

## Requirements
- R1: After reset the control, count and status registers read 0. SCLK is low, and both chip-select lines are low, because the polarity bit resets to active-high.
- R2: A write to offset 0x04 pushes its low byte into the TX FIFO. The status register at 0x28 reports the RX fill level in bits 6:0 and the TX fill level in bits 22:16. A FIFO holds 64 bytes, and a push to a full FIFO is dropped.
- R3: A read of offset 0x00 pops the RX FIFO and returns the bytes in arrival order in bits 7:0.
- R4: The burst count (0x20) and the transmit count (0x24) keep only write bits 23:0 and read them back.
- R5: A write to control (0x08) with bit 10 set, enable (bit 0) set and master (bit 1) set starts a burst of burst-count bytes. Nothing starts if enable or master is clear, or if the burst count is 0.
- R6: Control bit 10 reads 1 from the cycle after the starting write. It reads 0 again once the last byte of the burst is in the RX FIFO.
- R7: The first transmit-count bytes of a burst come from the TX FIFO. Any further bytes are sent as 0x00, and their received data is still captured.
- R8: Bits go out MSB first. SCLK idles at CPOL (bit 3). With CPHA (bit 2) at 0, data is sampled on the leading SCLK edge. With CPHA at 1, data is sampled on the trailing SCLK edge.
- R9: Every byte received in a burst is pushed into the RX FIFO.
- R10: Writing 1 to bit 8 empties the TX FIFO, and writing 1 to bit 9 empties the RX FIFO. The other FIFO is left as it was. Each of these bits reads 1 in the cycle after the write and 0 one cycle later.
- R11: With manual mode (bit 16) set, the line chosen by bits 13:12 follows the level bit (bit 17). The other line sits at its inactive level.
- R12: With manual mode clear, the chosen line is at its active level while a burst runs and at its inactive level otherwise.
- R13: Bit 4 set makes the chip-select lines active-low, with an inactive level of 1. Bit 4 clear makes them active-high, with an inactive level of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_en | input | 1 | Half-period pulse from the clock divider |
| miso | input | 1 | Serial data from the device |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the RX FIFO at offset 0x00) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| cs_o | output | 2 | Chip-select lines |

## Verification
A register write takes effect at the clock edge that ends the write cycle. The exchange bit therefore reads 1 at the next falling edge. A FIFO reset bit reads 1 at that same falling edge, and the fill level reads 0 one edge later. The bench drives and samples the bus only on falling edges, and its checks follow this timing. A behavioural SPI device model, aware of the clock phase and polarity, records the bytes it receives and answers with a known byte sequence. The bench polls the exchange bit until it clears, and only then compares what the device model captured and what the RX FIFO holds.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_RXD  = 6'h00;
  localparam logic [ADDR_W-1:0] A_TXD  = 6'h04;
  localparam logic [ADDR_W-1:0] A_CTL  = 6'h08;
  localparam logic [ADDR_W-1:0] A_BCNT = 6'h20;
  localparam logic [ADDR_W-1:0] A_TCNT = 6'h24;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h28;

  localparam int B_EN    = 0;
  localparam int B_MST   = 1;
  localparam int B_CPHA  = 2;
  localparam int B_CPOL  = 3;
  localparam int B_CSAL  = 4;
  localparam int B_TXRST = 8;
  localparam int B_RXRST = 9;
  localparam int B_XCH   = 10;
  localparam int B_SEL0  = 12;
  localparam int B_MAN   = 16;
  localparam int B_LVL   = 17;

  typedef enum logic [1:0] {
    EN_IDLE  = 2'd0,
    EN_LOAD  = 2'd1,
    EN_SHIFT = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spx_byte_fifo.sv
module spx_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = empty ? '0 : mem[rptr_q];
  assign level   = lvl_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (do_push) wptr_d = wptr_q + 1'b1;
      if (do_pop)  rptr_d = rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));

  assert_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/spx_shifter.sv
module spx_shifter
  import spx_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [7:0]       tx_data,
  input  logic             tx_empty,
  input  logic             miso,
  output logic             busy,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             sclk,
  output logic             mosi
);
  eng_state_e       st_q, st_d;
  logic [CNT_W-1:0] left_q, left_d, txl_q, txl_d;
  logic [7:0]       sh_q, sh_d, rx_q, rx_d, ld_byte, rx_full;
  logic [2:0]       bit_q, bit_d;
  logic             half_q, half_d, mosi_q, mosi_d;

  assign busy    = (st_q != EN_IDLE);
  assign sclk    = cpol ^ half_q;
  assign mosi    = mosi_q;
  assign rx_full = cpha ? {rx_q[6:0], miso} : rx_q;
  assign ld_byte = (txl_q != '0 && !tx_empty) ? tx_data : 8'h00;

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    txl_d   = txl_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    bit_d   = bit_q;
    half_d  = half_q;
    mosi_d  = mosi_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    rx_byte = rx_full;
    case (st_q)
      EN_IDLE: begin
        if (start && burst_len != '0) begin
          left_d = burst_len;
          txl_d  = tx_len;
          st_d   = EN_LOAD;
        end
      end
      EN_LOAD: begin
        tx_pop = (txl_q != '0) && !tx_empty;
        if (txl_q != '0) txl_d = txl_q - 1'b1;
        if (cpha) begin
          sh_d = ld_byte;
        end else begin
          mosi_d = ld_byte[7];
          sh_d   = {ld_byte[6:0], 1'b0};
        end
        bit_d  = '0;
        half_d = 1'b0;
        st_d   = EN_SHIFT;
      end
      EN_SHIFT: begin
        if (tick) begin
          if (!half_q) begin
            half_d = 1'b1;
            if (!cpha) begin
              rx_d = {rx_q[6:0], miso};
            end else begin
              mosi_d = sh_q[7];
              sh_d   = {sh_q[6:0], 1'b0};
            end
          end else begin
            half_d = 1'b0;
            rx_d   = rx_full;
            if (bit_q == 3'd7) begin
              rx_push = 1'b1;
              left_d  = left_q - 1'b1;
              st_d    = (left_q == CNT_W'(1)) ? EN_IDLE : EN_LOAD;
            end else begin
              bit_d = bit_q + 1'b1;
              if (!cpha) begin
                mosi_d = sh_q[7];
                sh_d   = {sh_q[6:0], 1'b0};
              end
            end
          end
        end
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      left_q <= '0;
      txl_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      txl_q  <= txl_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      half_q <= half_d;
      mosi_q <= mosi_d;
    end
  end

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

  assert_bit_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EN_SHIFT && !tick) |=> $stable(bit_q));
endmodule

// File: rtl/spx_master_top.sv
module spx_master_top
  import spx_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24,
  parameter int NCS        = 2,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1,
  localparam int PAD_W     = 16 - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_en,
  input  logic              miso,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    cs_o
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             en_q, mst_q, cpha_q, cpol_q, csal_q, man_q, lvl_q;
  logic [1:0]       sel_q;
  logic             txrst_q, rxrst_q;
  logic [CNT_W-1:0] bcnt_q, tcnt_q;
  logic             wr_ctl, start, busy;
  logic             tx_pop, rx_push, tx_empty, rx_empty;
  logic             tx_full, rx_full;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;

  assign wr_ctl = bus_wr && (bus_addr == A_CTL);
  assign start  = wr_ctl && bus_wdata[B_XCH] && bus_wdata[B_EN]
                  && bus_wdata[B_MST] && !busy;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      csal_q  <= 1'b0;
      man_q   <= 1'b0;
      lvl_q   <= 1'b0;
      sel_q   <= '0;
      txrst_q <= 1'b0;
      rxrst_q <= 1'b0;
      bcnt_q  <= '0;
      tcnt_q  <= '0;
    end else begin
      txrst_q <= wr_ctl && bus_wdata[B_TXRST];
      rxrst_q <= wr_ctl && bus_wdata[B_RXRST];
      if (wr_ctl) begin
        en_q   <= bus_wdata[B_EN];
        mst_q  <= bus_wdata[B_MST];
        cpha_q <= bus_wdata[B_CPHA];
        cpol_q <= bus_wdata[B_CPOL];
        csal_q <= bus_wdata[B_CSAL];
        sel_q  <= bus_wdata[B_SEL0+1:B_SEL0];
        man_q  <= bus_wdata[B_MAN];
        lvl_q  <= bus_wdata[B_LVL];
      end
      if (bus_wr && bus_addr == A_BCNT) bcnt_q <= bus_wdata[CNT_W-1:0];
      if (bus_wr && bus_addr == A_TCNT) tcnt_q <= bus_wdata[CNT_W-1:0];
    end
  end

  spx_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txf (
    .clk(clk), .rst_n(rst_sync_q), .clr(txrst_q),
    .push(bus_wr && bus_addr == A_TXD), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_head), .level(tx_lvl),
    .empty(tx_empty), .full(tx_full)
  );

  spx_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxf (
    .clk(clk), .rst_n(rst_sync_q), .clr(rxrst_q),
    .push(rx_push), .din(rx_byte),
    .pop(bus_rd && bus_addr == A_RXD), .dout(rx_head), .level(rx_lvl),
    .empty(rx_empty), .full(rx_full)
  );

  spx_shifter #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_sync_q), .tick(sclk_en), .start(start),
    .burst_len(bcnt_q), .tx_len(tcnt_q), .cpol(cpol_q), .cpha(cpha_q),
    .tx_data(tx_head), .tx_empty(tx_empty), .miso(miso),
    .busy(busy), .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .sclk(sclk), .mosi(mosi)
  );

  generate
    for (genvar g = 0; g < NCS; g++) begin : g_cs
      logic chosen;
      assign chosen = (sel_q == 2'(g));
      always_comb begin
        if (chosen && man_q)      cs_o[g] = lvl_q;
        else if (chosen && busy)  cs_o[g] = !csal_q;
        else                      cs_o[g] = csal_q;
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RXD:  bus_rdata = {24'h0, rx_head};
      A_CTL: begin
        bus_rdata[B_EN]    = en_q;
        bus_rdata[B_MST]   = mst_q;
        bus_rdata[B_CPHA]  = cpha_q;
        bus_rdata[B_CPOL]  = cpol_q;
        bus_rdata[B_CSAL]  = csal_q;
        bus_rdata[B_TXRST] = txrst_q;
        bus_rdata[B_RXRST] = rxrst_q;
        bus_rdata[B_XCH]   = busy;
        bus_rdata[B_SEL0+1:B_SEL0] = sel_q;
        bus_rdata[B_MAN]   = man_q;
        bus_rdata[B_LVL]   = lvl_q;
      end
      A_BCNT: bus_rdata = 32'(bcnt_q);
      A_TCNT: bus_rdata = 32'(tcnt_q);
      A_STAT: bus_rdata = {{PAD_W{1'b0}}, tx_lvl, {PAD_W{1'b0}}, rx_lvl};
      default: bus_rdata = '0;
    endcase
  end

  assert_xch_clears_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(busy) |-> $past(rx_push));

  assert_start_by_write_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(busy) |-> $past(bus_wr));
endmodule

// File: tb/sim_spx_master_top.sv
module sim_spx_master_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_en = 1'b0;
  logic        miso = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi;
  logic [1:0]  cs_o;

  int checks = 0;
  int errors = 0;

  spx_master_top u0 (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .miso(miso),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .cs_o(cs_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) sclk_en <= ~sclk_en;

  function automatic logic [7:0] resp(input int i);
    return 8'h3C + 8'(i) * 8'h11;
  endfunction
  function automatic logic [7:0] txb(input int i, input int salt);
    return 8'h81 + 8'(i) * 8'h17 + 8'(salt);
  endfunction
  function automatic logic [31:0] mk_ctl(input bit cpol, input bit cpha, input bit xch);
    return 32'h13 | (32'(cpha) << 2) | (32'(cpol) << 3) | (32'(xch) << 10);
  endfunction

  // device model
  bit         s_on = 0, b_cpol = 0, b_cpha = 0;
  logic [7:0] s_sh, s_rx;
  int         s_bit, s_idx;
  logic [7:0] s_got [16];

  always @(sclk) begin
    if (s_on) begin
      if (sclk != b_cpol) begin
        if (!b_cpha) s_rx = {s_rx[6:0], mosi};
        else begin miso = s_sh[7]; s_sh = {s_sh[6:0], 1'b0}; end
      end else begin
        if (b_cpha) s_rx = {s_rx[6:0], mosi};
        else s_sh = {s_sh[6:0], 1'b0};
        s_bit++;
        if (s_bit == 8) begin
          if (s_idx < 16) s_got[s_idx] = s_rx;
          s_idx++;
          s_bit = 0;
          s_sh = resp(s_idx);
        end
        if (!b_cpha) miso = s_sh[7];
      end
    end
  end

  task automatic slv_arm();
    s_idx = 0; s_bit = 0; s_sh = resp(0); s_rx = 0;
    miso = b_cpha ? 1'b0 : s_sh[7];
    s_on = 1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd32(input logic [5:0] a, input bit pop, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = pop;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'h400;
    for (int k = 0; k < 4000 && v[10]; k++) rd32(6'h08, 0, v);
    chk("R6 exchange bit cleared", 32'(v[10]), 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd32(6'h08, 0, v); chk("R1 control", v, 0);
    rd32(6'h28, 0, v); chk("R1 status", v, 0);
    rd32(6'h20, 0, v); chk("R1 burst count", v, 0);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 R13 cs idle active-high", 32'(cs_o), 0);
  endtask

  task automatic t_counts();
    logic [31:0] v;
    wr32(6'h20, 32'hFF12_3456); rd32(6'h20, 0, v); chk("R4 burst count", v, 32'h0012_3456);
    wr32(6'h24, 32'hA0FF_FFFF); rd32(6'h24, 0, v); chk("R4 transmit count", v, 32'h00FF_FFFF);
  endtask

  task automatic t_txfifo();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) wr32(6'h04, 32'(txb(i, 0)));
    rd32(6'h28, 0, v); chk("R2 tx level 3", v, 32'h0003_0000);
    for (int i = 0; i < 62; i++) wr32(6'h04, 32'(i));
    rd32(6'h28, 0, v); chk("R2 tx level full 64", v, 32'h0040_0000);
    wr32(6'h08, 32'h100);
    #1 v = bus_rdata; chk("R10 tx reset bit reads 1", 32'(v[8]), 1);
    rd32(6'h28, 0, v); chk("R10 tx emptied", v, 0);
    rd32(6'h08, 0, v); chk("R10 tx reset bit self-clears", 32'(v[8]), 0);
  endtask

  task automatic run_burst(input bit cpol, input bit cpha, input int n, input int tcount,
                           input int salt);
    logic [31:0] v;
    b_cpol = cpol; b_cpha = cpha; s_on = 0;
    wr32(6'h08, mk_ctl(cpol, cpha, 0));
    wr32(6'h20, 32'(n));
    wr32(6'h24, 32'(tcount));
    for (int i = 0; i < tcount; i++) wr32(6'h04, 32'(txb(i, salt)));
    slv_arm();
    chk("R8 sclk idles at CPOL", 32'(sclk), 32'(cpol));
    wr32(6'h08, mk_ctl(cpol, cpha, 1));
    #1 v = bus_rdata;
    chk("R6 exchange bit set", 32'(v[10]), 1);
    chk("R12 R13 cs asserted low in burst", 32'(cs_o), 32'b10);
    wait_idle();
    s_on = 0;
    chk("R5 byte count at device", 32'(s_idx), 32'(n));
    for (int i = 0; i < n; i++)
      chk(i < tcount ? "R8 device got tx byte" : "R7 zero fill byte",
          32'(s_got[i]), i < tcount ? 32'(txb(i, salt)) : 0);
    rd32(6'h28, 0, v); chk("R9 rx level", v, 32'(n));
    for (int i = 0; i < n; i++) begin
      rd32(6'h00, 1, v); chk("R3 R9 rx byte", v, 32'(resp(i)));
    end
    chk("R12 cs released", 32'(cs_o), 32'b11);
    chk("R8 sclk back at CPOL", 32'(sclk), 32'(cpol));
  endtask

  task automatic t_no_start();
    logic [31:0] v;
    wr32(6'h20, 32'd1);
    wr32(6'h04, 32'h55);
    wr32(6'h08, 32'h0000_0402);
    #1 v = bus_rdata; chk("R5 no start without enable", 32'(v[10]), 0);
    wr32(6'h20, 32'd0);
    wr32(6'h08, 32'h0000_0413);
    #1 v = bus_rdata; chk("R5 no start on zero count", 32'(v[10]), 0);
    rd32(6'h28, 0, v); chk("R5 tx byte untouched", v, 32'h0001_0000);
    wr32(6'h08, 32'h0000_0113);
  endtask

  task automatic t_rxreset();
    logic [31:0] v;
    run_burst(0, 0, 2, 2, 9);
    wr32(6'h04, 32'h77);
    b_cpol = 0; b_cpha = 0; slv_arm();
    wr32(6'h20, 32'd2); wr32(6'h24, 32'd0);
    wr32(6'h08, mk_ctl(0, 0, 1));
    wait_idle(); s_on = 0;
    wr32(6'h08, 32'h213);
    #1 v = bus_rdata; chk("R10 rx reset bit reads 1", 32'(v[9]), 1);
    rd32(6'h28, 0, v); chk("R10 rx emptied, tx kept", v, 32'h0001_0000);
    wr32(6'h08, 32'h113);
  endtask

  task automatic t_manual_cs();
    wr32(6'h08, 32'h0001_1013);
    chk("R11 manual low on line 1", 32'(cs_o), 32'b01);
    wr32(6'h08, 32'h0003_1013);
    chk("R11 manual high on line 1", 32'(cs_o), 32'b11);
    wr32(6'h08, 32'h0000_0003);
    chk("R13 active-high idle", 32'(cs_o), 32'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_counts();
    t_txfifo();
    t_no_start();
    run_burst(0, 0, 3, 3, 1);
    run_burst(0, 1, 2, 2, 2);
    run_burst(1, 0, 2, 2, 3);
    run_burst(1, 1, 3, 3, 4);
    run_burst(0, 0, 4, 2, 5);
    t_rxreset();
    t_manual_cs();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule